// File: doc/BRIEF.md
# Light-Load Switching Mode Controller

This block times the gate requests of a single synchronous buck stage. It derives a nominal switching period from a three-level frequency select and runs each switching cycle as a fixed sequence. The cycle opens with a dead interval and then a high-side on-pulse whose width is a fixed fraction of the period. A second dead interval follows, and the cycle closes with a low-side conduction phase. A three-level mode select decides how that low-side phase ends and what opens the next cycle.

In continuous mode the cycles run back to back at the nominal rate, and the low side conducts until the next cycle whatever the inductor current does. In discontinuous mode the low side is released when the inductor current reaches zero. Both switches then stay off until the modulator asks for a new on-pulse, and that request is honoured no sooner than one nominal period after the previous cycle began. The third mode behaves like the discontinuous mode, with one addition. A watchdog counts from the start of every cycle and forces a new one before the switching rate can drop below about 28 kHz, which keeps it above the audible band. The analog modulator and the current sensing sit outside this block. It sees only a request flag and a zero-current flag.

Top module: `lls_ctrl`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same cycle.
- R2: Between one gate falling and the other rising, both gates are low for exactly DEAD_CYC cycles.
- R3: The nominal period in clock cycles is CLK_HZ/400000 for `freq_sel`=0, CLK_HZ/800000 for `freq_sel`=1, and 3*CLK_HZ/1600000 for `freq_sel`=2 or 3 (floating). In continuous mode, `hs_gate` rises once every nominal period.
- R4: Each high-side pulse lasts period/ON_DIV cycles, rounded down, and begins DEAD_CYC cycles after the cycle boundary.
- R5: With `mode_sel`=1 (continuous), the low side conducts from its dead interval until the next cycle boundary, for period-2*DEAD_CYC-period/ON_DIV cycles, and `zero_cur` has no effect.
- R6: With `mode_sel`=0 (discontinuous), `zero_cur` sampled high during low-side conduction turns both gates off from the next cycle on. They stay off until `pwm_req` is sampled high at least one nominal period after the previous cycle start. `hs_gate` then rises DEAD_CYC+1 cycles after that sample.
- R7: With `mode_sel`=2 or 3 (audio), behaviour is as in R6. In addition, a new cycle is forced when floor(CLK_HZ/28000) cycles have passed since the previous cycle start with no honoured request.
- R8: The audio watchdog restarts at every cycle start, whether requested or forced. A request that lands in the same cycle as the watchdog expiry produces a single cycle.
- R9: A change of `mode_sel` or `freq_sel` takes effect at the next cycle boundary. While both gates are idle, the current inputs apply at once.
- R10: During reset and after it, both gates are low. In discontinuous mode, no pulse is issued until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_req | input | 1 | On-pulse request from the modulator |
| zero_cur | input | 1 | Inductor current has reached zero |
| freq_sel | input | 2 | Decoded frequency pin: 0 low, 1 high, 2/3 floating |
| mode_sel | input | 2 | Decoded mode pin: 0 low, 1 high, 2/3 floating |
| hs_gate | output | 1 | High-side switch on request |
| ls_gate | output | 1 | Low-side switch on request |

## Verification
In audio mode, the watchdog expiry and a modulator request can both ask for a new cycle in the same clock. The bench records when the last forced pulse rose and drives a one-cycle request into the cycle just before the next forced start is due. It then expects exactly one high-side pulse at the forced time, followed by the next forced pulse a full watchdog window later. A second pulse, or a shifted one, fails the check. The same technique places mode and frequency changes inside a running cycle, to check that the cycle in progress completes under its old settings.

// File: rtl/lls_ctrl.sv
module lls_ctrl #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int DEAD_CYC = 2,
  parameter int ON_DIV   = 4,
  parameter int GUARD_HZ = 28_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_req,
  input  logic       zero_cur,
  input  logic [1:0] freq_sel,
  input  logic [1:0] mode_sel,
  output logic       hs_gate,
  output logic       ls_gate
);

  localparam int PER_HI  = CLK_HZ / 800_000;
  localparam int PER_MID = (CLK_HZ * 3) / 1_600_000;
  localparam int PER_LO  = CLK_HZ / 400_000;
  localparam int GUARD   = CLK_HZ / GUARD_HZ;
  localparam int CW      = $clog2(GUARD + 1);
  localparam logic [CW-1:0] G_MAX = CW'(GUARD - 1);

  typedef enum logic [2:0] {S_IDLE, S_DH, S_HS, S_DL, S_LS} st_t;
  typedef enum logic [1:0] {M_DCM, M_CCM, M_AUD} mode_t;
  typedef enum logic [1:0] {F_LO, F_HI, F_MID} fq_t;

  st_t st;
  mode_t mode_q, mode_live, mode_cur;
  fq_t fq_q, fq_live, fq_cur;
  logic [CW-1:0] elapsed, ph, per_cur, ton_q;
  logic idle, ready, guard_hit, start;

  assign mode_live = (mode_sel == 2'd0) ? M_DCM : (mode_sel == 2'd1) ? M_CCM : M_AUD;
  assign fq_live   = (freq_sel == 2'd0) ? F_LO  : (freq_sel == 2'd1) ? F_HI  : F_MID;

  assign idle     = (st == S_IDLE);
  assign mode_cur = idle ? mode_live : mode_q;
  assign fq_cur   = idle ? fq_live : fq_q;

  assign per_cur = (fq_cur == F_LO) ? CW'(PER_LO) :
                   (fq_cur == F_HI) ? CW'(PER_HI) : CW'(PER_MID);
  assign ton_q   = (fq_q == F_LO) ? CW'(PER_LO / ON_DIV) :
                   (fq_q == F_HI) ? CW'(PER_HI / ON_DIV) : CW'(PER_MID / ON_DIV);

  assign ready     = elapsed >= per_cur - CW'(1);
  assign guard_hit = elapsed == G_MAX;
  assign start     = (mode_cur == M_CCM) ? ready :
                     ((ready && pwm_req) || (mode_cur == M_AUD && guard_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      elapsed <= G_MAX;
      ph      <= '0;
      mode_q  <= M_DCM;
      fq_q    <= F_LO;
    end else begin
      elapsed <= start ? '0 : (guard_hit ? elapsed : elapsed + CW'(1));
      if (start) begin
        st     <= S_DH;
        ph     <= CW'(DEAD_CYC - 1);
        mode_q <= mode_live;
        fq_q   <= fq_live;
      end else begin
        case (st)
          S_DH: if (ph == '0) begin st <= S_HS; ph <= ton_q - CW'(1); end
                else ph <= ph - CW'(1);
          S_HS: if (ph == '0) begin st <= S_DL; ph <= CW'(DEAD_CYC - 1); end
                else ph <= ph - CW'(1);
          S_DL: if (ph == '0) st <= S_LS;
                else ph <= ph - CW'(1);
          S_LS: if (mode_q != M_CCM && zero_cur) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign hs_gate = (st == S_HS);
  assign ls_gate = (st == S_LS);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_gate, ls_gate}));

  a_r2_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> !$past(hs_gate));

  a_r2_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> !$past(ls_gate));

  a_r6_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate && zero_cur && mode_q != M_CCM) |=> !ls_gate);

  a_r5_ccm_keeps_ls: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate && mode_q == M_CCM && !ready) |=> ls_gate);

endmodule

// File: tb/lls_ctrl_bench.sv
`timescale 1ns/100ps
module lls_ctrl_bench;
  localparam int CLK  = 8_000_000;
  localparam int DEAD = 1;
  localparam int DIV  = 4;
  localparam int P_HI  = CLK / 800_000;
  localparam int P_MID = (CLK * 3) / 1_600_000;
  localparam int P_LO  = CLK / 400_000;
  localparam int GRD   = CLK / 28_000;

  logic clk = 0, rst_n = 0, pwm_req = 0, zero_cur = 1;
  logic [1:0] freq_sel = 2'd1, mode_sel = 2'd0;
  logic hs_gate, ls_gate;

  int checks = 0, errors = 0, cyc = 0;
  int rise_cnt = 0, last_rise = 0, prev_rise = 0, hs_fall = 0, hs_width = 0;
  int ls_rise = 0, ls_fall = 0, ls_width = 0, ls_fall_cnt = 0, overlap = 0;
  logic hs_d = 0, ls_d = 0;

  lls_ctrl #(.CLK_HZ(CLK), .DEAD_CYC(DEAD), .ON_DIV(DIV)) u_lls_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .zero_cur(zero_cur),
    .freq_sel(freq_sel), .mode_sel(mode_sel), .hs_gate(hs_gate), .ls_gate(ls_gate));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (hs_gate && ls_gate) overlap = overlap + 1;
    if (hs_gate && !hs_d) begin prev_rise = last_rise; last_rise = cyc; rise_cnt = rise_cnt + 1; end
    if (!hs_gate && hs_d) begin hs_fall = cyc; hs_width = cyc - last_rise; end
    if (ls_gate && !ls_d) ls_rise = cyc;
    if (!ls_gate && ls_d) begin ls_fall = cyc; ls_width = cyc - ls_rise; ls_fall_cnt = ls_fall_cnt + 1; end
    hs_d = hs_gate;
    ls_d = ls_gate;
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    int b = rise_cnt;
    while (rise_cnt == b) step();
  endtask

  task automatic wait_ls_fall();
    int b = ls_fall_cnt;
    while (ls_fall_cnt == b) step();
  endtask

  function automatic int per_of(input int code);
    return (code == 0) ? P_LO : (code == 1) ? P_HI : P_MID;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, b, tgt;
    repeat (5) step();
    chk("R10 reset hs", hs_gate, 0);
    chk("R10 reset ls", ls_gate, 0);
    rst_n = 1;
    repeat (400) step();
    chk("R10 R6 no pulse without request", rise_cnt, 0);

    // R6 single request latency, release on zero current
    c = cyc; pwm_req = 1; step(); pwm_req = 0;
    wait_rise();
    chk("R6 request latency", last_rise, c + 1 + DEAD);
    wait_ls_fall();
    chk("R6 ls released by zero current", ls_width, 1);
    b = rise_cnt;
    repeat (300) step();
    chk("R6 stays off", rise_cnt, b);

    // R6 held request: minimum period
    freq_sel = 2'd2; pwm_req = 1;
    wait_rise(); wait_rise();
    chk("R6 min period mid", last_rise - prev_rise, P_MID);
    wait_rise();
    chk("R6 min period mid again", last_rise - prev_rise, P_MID);

    // R7 audio watchdog
    mode_sel = 2'd3; pwm_req = 0;
    wait_rise(); wait_rise();
    chk("R7 forced interval", last_rise - prev_rise, GRD);

    // R8 coincident request and expiry
    tgt = last_rise + GRD - DEAD - 1;
    while (cyc != tgt) step();
    pwm_req = 1; step(); pwm_req = 0;
    b = rise_cnt;
    wait_rise();
    chk("R8 coincident start time", last_rise - prev_rise, GRD);
    wait_rise();
    chk("R8 coincident next forced", last_rise - prev_rise, GRD);
    chk("R8 single pulse", rise_cnt, b + 2);

    // R8 restart on requested pulse
    repeat (100) step();
    c = cyc; pwm_req = 1; step(); pwm_req = 0;
    wait_rise();
    chk("R7 request honoured in audio", last_rise, c + 1 + DEAD);
    wait_rise();
    chk("R8 watchdog restarted", last_rise - prev_rise, GRD);

    // R3 R4 R5 R2 continuous mode, all frequency codes
    mode_sel = 2'd1;
    for (int code = 0; code < 4; code++) begin
      int p, t;
      freq_sel = 2'(code);
      p = per_of(code); t = p / DIV;
      wait_rise(); wait_rise(); wait_rise();
      chk($sformatf("R3 period code %0d", code), last_rise - prev_rise, p);
      chk($sformatf("R4 hs width code %0d", code), hs_width, t);
      chk($sformatf("R5 ls width code %0d", code), ls_width, p - 2 * DEAD - t);
      chk($sformatf("R2 gap hs->ls code %0d", code), ls_rise - hs_fall, DEAD);
      chk($sformatf("R2 gap ls->hs code %0d", code), last_rise - ls_fall, DEAD);
    end

    // R9 frequency change mid-cycle
    freq_sel = 2'd1;
    wait_rise(); wait_rise();
    freq_sel = 2'd0;
    wait_rise();
    chk("R9 current cycle keeps period", last_rise - prev_rise, P_HI);
    wait_rise();
    chk("R9 next cycle new period", last_rise - prev_rise, P_LO);

    // R9 mode change mid-cycle
    freq_sel = 2'd1;
    wait_rise(); wait_rise();
    while (!ls_gate) step();
    mode_sel = 2'd0;
    wait_ls_fall();
    chk("R9 R5 ccm cycle completes", ls_width, P_HI - 2 * DEAD - P_HI / DIV);
    b = rise_cnt;
    wait_ls_fall();
    chk("R9 next cycle discontinuous", ls_width, 1);
    repeat (200) step();
    chk("R9 one boundary pulse only", rise_cnt, b + 1);

    chk("R1 no overlap", overlap, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule